// File: doc/BRIEF.md
# Adaptive Single/Double Error Corrector

This block is the correction stage of a short double-error-correcting, triple-error-detecting binary BCH decoder over GF(2^7). The code is shortened to 79 bits: 64 data bits and 15 check bits. Upstream logic supplies three inputs: the two odd syndromes, a 2-bit error-count flag and the received word. From these the block produces the corrected 64 data bits in the same cycle. It is purely combinational.

The flag chooses one of two correctors. When it reports a single error, a matcher compares the first syndrome with every column of the alpha-power check matrix. When it reports two errors, a reversed error-locator polynomial is formed from the syndromes and evaluated at every word position in parallel. Error-free and triple-error words skip both correctors: their error vector is zero. The selected error vector is XORed into the word. Two status outputs report whether any bit was flipped and whether the word must be treated as uncorrectable.

Top module: `bch_adaptive_fix`

## Requirements
- R1: With flag 2'b00 (no error), data_o equals word_i[78:15] unchanged, and fixed_o and uncorr_o are 0.
- R2: With flag 2'b01 (one error), if s1_i equals alpha^p for a position p in 0..78, bit p of the word is inverted and fixed_o is 1. Bit p of word_i is the codeword coefficient of alpha^p, and alpha is a root of x^7 + x^3 + 1.
- R3: With flag 2'b10 (two errors), when exactly two positions p and q in 0..78 are roots of (s1^3 + s3) + s1^2*x + s1*x^2, bits p and q are inverted, fixed_o is 1 and uncorr_o is 0.
- R4: With flag 2'b10, when the number of roots within positions 0..78 is not exactly two, no bit is changed, uncorr_o is 1 and fixed_o is 0.
- R5: With flag 2'b11 (three errors detected), no bit is changed, uncorr_o is 1 and fixed_o is 0.
- R6: data_o is bits 78..15 of the corrected word. A correction at a check-bit position (0..14) raises fixed_o but leaves data_o equal to the received data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| s1_i | input | 7 | First syndrome, sum of alpha^p over the error positions |
| s3_i | input | 7 | Third-power syndrome, sum of alpha^(3p) over the error positions |
| flag_i | input | 2 | Error-count class: 00 none, 01 one, 10 two, 11 three |
| word_i | input | 79 | Received word, bit p at position p |
| data_o | output | 64 | Corrected data bits (word bits 78..15) |
| fixed_o | output | 1 | At least one bit was inverted |
| uncorr_o | output | 1 | Word could not be corrected and passes through as received |

## Verification
Two functions can fall in the same cycle: raising the uncorrectable status and suppressing the correction. A two-error flag whose polynomial has the wrong number of in-range roots must do both at once. The bench provokes this in two ways: it feeds single-error syndromes under a two-error flag, and it feeds a pair in which one error sits in the shortened-away positions. It then requires uncorr_o high, fixed_o low and data_o equal to the received data bits in that one sample. The remaining checks sweep every single-error position and every in-range error pair, and compare data_o against the original data.

// File: rtl/bch_adaptive_fix.sv
module bch_adaptive_fix #(
  parameter int M = 7,
  parameter int N = 79,
  parameter int K = 64,
  parameter logic [M-1:0] POLY = 7'h09
) (
  input  logic [M-1:0] s1_i,
  input  logic [M-1:0] s3_i,
  input  logic [1:0]   flag_i,
  input  logic [N-1:0] word_i,
  output logic [K-1:0] data_o,
  output logic         fixed_o,
  output logic         uncorr_o
);
  localparam int P = N - K;

  function automatic logic [M-1:0] xt(input logic [M-1:0] a);
    return {a[M-2:0], 1'b0} ^ (a[M-1] ? POLY : '0);
  endfunction

  function automatic logic [M-1:0] gmul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] acc, t;
    acc = '0;
    t = a;
    for (int k = 0; k < M; k++) begin
      if (b[k]) acc = acc ^ t;
      t = xt(t);
    end
    return acc;
  endfunction

  function automatic logic [M-1:0] apow(input int e);
    logic [M-1:0] r;
    r = 1;
    for (int k = 0; k < e; k++) r = xt(r);
    return r;
  endfunction

  logic [M-1:0] sq, cu, sig0;
  logic [N-1:0] hit1, hit2, evec;
  logic         two_roots;

  assign sq   = gmul(s1_i, s1_i);
  assign cu   = gmul(sq, s1_i);
  assign sig0 = cu ^ s3_i;

  for (genvar i = 0; i < N; i++) begin : g_pos
    localparam logic [M-1:0] A1 = apow(i);
    localparam logic [M-1:0] A2 = apow(2 * i);
    assign hit1[i] = (s1_i == A1);
    assign hit2[i] = ((sig0 ^ gmul(sq, A1) ^ gmul(s1_i, A2)) == '0);
  end

  assign two_roots = ($countones(hit2) == 2);

  always_comb begin
    case (flag_i)
      2'b01:   evec = hit1;
      2'b10:   evec = two_roots ? hit2 : '0;
      default: evec = '0;
    endcase
  end

  logic [N-1:0] fixed_word;
  assign fixed_word = word_i ^ evec;
  assign data_o     = fixed_word[N-1:P];
  assign fixed_o    = |evec;
  assign uncorr_o   = (flag_i == 2'b11) || (flag_i == 2'b10 && !two_roots);

  always_comb begin
    // R1
    clean_pass_chk: assert (flag_i != 2'b00 || (data_o == word_i[N-1:P] && !fixed_o));
    // R2
    single_flip_chk: assert (flag_i != 2'b01 || $onehot0(fixed_word ^ word_i));
    // R3
    double_flip_chk: assert (flag_i != 2'b10 || uncorr_o || $countones(fixed_word ^ word_i) == 2);
    // R4
    uncorr_hold_chk: assert (!uncorr_o || (data_o == word_i[N-1:P] && !fixed_o));
  end
endmodule

// File: tb/tb_bch_adaptive_fix.sv
module tb_bch_adaptive_fix;
  logic clk = 0;
  always #2 clk = ~clk;

  logic [6:0]  s1, s3;
  logic [1:0]  flag;
  logic [78:0] word;
  logic [63:0] data;
  logic        fixed, uncorr;
  int checks = 0, errors = 0;

  bch_adaptive_fix dut (.s1_i(s1), .s3_i(s3), .flag_i(flag), .word_i(word),
                        .data_o(data), .fixed_o(fixed), .uncorr_o(uncorr));

  function automatic logic [6:0] ax(input logic [6:0] a);
    return {a[5:0], 1'b0} ^ (a[6] ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] pw(input int e);
    logic [6:0] r = 7'd1;
    for (int k = 0; k < e; k++) r = ax(r);
    return r;
  endfunction

  logic [6:0] ptab[0:400];

  task automatic chk(input string req, input logic ok, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [6:0] a, input logic [6:0] b, input logic [1:0] f, input logic [78:0] w);
    @(negedge clk);
    s1 = a; s3 = b; flag = f; word = w;
    #1;
  endtask

  task automatic expect_out(input string req, input logic [63:0] ed, input logic ef, input logic eu);
    chk(req, data == ed && fixed == ef && uncorr == eu, {data, fixed, uncorr}, {ed, ef, eu});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [78:0] cw, e;
    for (int k = 0; k <= 400; k++) ptab[k] = pw(k);
    s1 = 0; s3 = 0; flag = 0; word = 0;
    #1;
    expect_out("R1 idle", 64'd0, 1'b0, 1'b0);

    // R1: clean words pass unchanged
    for (int t = 0; t < 8; t++) begin
      cw = {64'h9E37_79B9_7F4A_7C15 * (t + 1), 15'(t * 977)};
      apply(7'd0, 7'd0, 2'b00, cw);
      expect_out("R1 clean", cw[78:15], 1'b0, 1'b0);
    end

    // R2 and R6: every single position
    for (int p = 0; p < 79; p++) begin
      cw = {64'hC2B2_AE3D_27D4_EB4F ^ 64'(p * 40503), 15'(p * 131)};
      e = '0; e[p] = 1'b1;
      apply(ptab[p], ptab[(3 * p) % 127], 2'b01, cw ^ e);
      expect_out(p < 15 ? "R6 single in check bits" : "R2 single", cw[78:15], 1'b1, 1'b0);
    end

    // R3: every in-range pair
    for (int p = 0; p < 79; p++) begin
      for (int q = p + 1; q < 79; q++) begin
        cw = {64'h1656_67B1_9E37_79F9 + 64'(p * 79 + q), 15'(q)};
        e = '0; e[p] = 1'b1; e[q] = 1'b1;
        apply(ptab[p] ^ ptab[q], ptab[(3 * p) % 127] ^ ptab[(3 * q) % 127], 2'b10, cw ^ e);
        expect_out("R3 pair", cw[78:15], 1'b1, 1'b0);
      end
    end

    // R4: single-error syndromes under the two-error flag (one root only)
    for (int p = 0; p < 79; p += 7) begin
      cw = {64'hDEAD_BEEF_0BAD_F00D ^ 64'(p), 15'h5555};
      e = '0; e[p] = 1'b1;
      apply(ptab[p], ptab[(3 * p) % 127], 2'b10, cw ^ e);
      expect_out("R4 one root", (cw ^ e) >> 15, 1'b0, 1'b1);
    end
    // R4: pair with one member in the shortened-away range
    for (int p = 0; p < 79; p += 13) begin
      cw = {64'h0123_4567_89AB_CDEF, 15'(p)};
      e = '0; e[p] = 1'b1;
      apply(ptab[p] ^ ptab[100], ptab[(3 * p) % 127] ^ ptab[300 % 127], 2'b10, cw ^ e);
      expect_out("R4 out of range", (cw ^ e) >> 15, 1'b0, 1'b1);
    end
    // R4: zero S1 with nonzero S3 (no roots)
    cw = {64'hFFFF_0000_FFFF_0000, 15'h0F0F};
    apply(7'd0, 7'h2A, 2'b10, cw);
    expect_out("R4 no roots", cw[78:15], 1'b0, 1'b1);

    // R5: triple errors pass through
    for (int p = 0; p < 70; p += 9) begin
      cw = {64'hA5A5_5A5A_3C3C_C3C3 ^ 64'(p * 3), 15'h1234};
      e = '0; e[p] = 1'b1; e[p + 4] = 1'b1; e[p + 8] = 1'b1;
      apply(ptab[p] ^ ptab[p + 4] ^ ptab[p + 8],
            ptab[(3 * p) % 127] ^ ptab[(3 * (p + 4)) % 127] ^ ptab[(3 * (p + 8)) % 127],
            2'b11, cw ^ e);
      expect_out("R5 triple", (cw ^ e) >> 15, 1'b0, 1'b1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule